// File: doc/BRIEF.md
# External Interrupt Request Combiner

This block produces the single interrupt request line of a small microcontroller core. Its main source is a dedicated external pin that is active low. Up to `NUM_PORT` general-purpose port pins, which are active high, can be merged into the same request. Every external input is asynchronous to the core clock, so each one passes through a synchronizer chain of `SYNC_STAGES` flops before any decision is made.

Two option inputs are captured once, on the first clock after reset is released, and are then held for the rest of operation. The first option chooses the trigger mode: edge only, or edge plus level. The second option enables the port-pin merge. All sources are first converted to an active-high form and ORed together. A single detector then watches the combined signal: a rising edge of it sets a pending latch, and in level mode an active combined level also holds the request on. The latch is cleared by a core acknowledge pulse or by a software clear pulse. An active-high enable masks the output without discarding the pending state.

Top module: `xirq_unit`

## Requirements
- R1: While reset is asserted, and directly after it, `irq_req_o` is low. Reset clears the pending latch and the edge history.
- R2: In edge mode (`opt_level_i`=0 at capture), a falling edge on `irq_pin_n_i` raises `irq_req_o` on the clock edge that comes SYNC_STAGES+1 clock edges after the pin changes. It stays high until a clear.
- R3: In edge mode, a pin that stays low after an acknowledge does not raise the request again.
- R4: In level mode (`opt_level_i`=1 at capture), `irq_req_o` is high while the combined source is active, even after an acknowledge. It falls only once the source is inactive and the latch has been cleared.
- R5: With merge on (`opt_merge_i`=1 at capture), a rising edge on any `port_i[k]`, for k from 0 to NUM_PORT-1, raises the request. In level mode a high level on it holds the request.
- R6: With merge off, `port_i` has no effect on `irq_req_o`.
- R7: A one-cycle `ack_i` or `sw_clr_i` pulse clears the pending latch. If a new edge is detected in the same cycle as the clear, the latch stays set.
- R8: `irq_req_o` is low whenever `int_en_i` is low. A pending edge survives the masked period and appears again when `int_en_i` returns high.
- R9: Changes on `opt_level_i` or `opt_merge_i` after the capture clock have no effect on behaviour.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| opt_level_i | input | 1 | Mode option: 1 = edge plus level, 0 = edge only |
| opt_merge_i | input | 1 | Option: 1 = merge the port pins into the request |
| irq_pin_n_i | input | 1 | Dedicated interrupt pin, active low, asynchronous |
| port_i | input | NUM_PORT | Mergeable port pins, active high, asynchronous |
| ack_i | input | 1 | Acknowledge pulse from the core |
| sw_clr_i | input | 1 | Software clear pulse |
| int_en_i | input | 1 | Interrupt enable, active high |
| irq_req_o | output | 1 | Interrupt request to the core |

## Verification
The bench builds the block with NUM_PORT=4 and SYNC_STAGES=2. With these values every mergeable pin can be driven on its own, including the lowest and the highest. The request latency is three clock edges, which is short enough to place an acknowledge exactly on the cycle in which a second edge is detected. Each vector in the table re-captures the options through a fresh reset, so that every combination of mode and merge is reached both before and after an acknowledge.

// File: rtl/xirq_pkg.sv
package xirq_pkg;

    // Options captured once after reset
    typedef struct packed {
        logic level;   // 1: edge plus level, 0: edge only
        logic merge;   // 1: port pins merged into request
    } xirq_cfg_t;

    // Control state of the top level
    typedef struct packed {
        logic      armed;  // options have been captured
        xirq_cfg_t cfg;
    } xirq_ctl_t;

    // Detector state
    typedef struct packed {
        logic prev;  // combined source one clock earlier
        logic pend;  // pending latch
    } xirq_det_t;

endpackage

// File: rtl/xirq_sync.sv
module xirq_sync #(
    parameter int W      = 5,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    localparam int LAST = STAGES - 1;

    logic [STAGES-1:0][W-1:0] chain_d, chain_q;

    always_comb begin
        chain_d[0] = d_i;
        for (int i = 1; i < STAGES; i++) begin
            chain_d[i] = chain_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= chain_d;
        end
    end

    assign q_o = chain_q[LAST];

endmodule

// File: rtl/xirq_merge.sv
module xirq_merge #(
    parameter int NUM_PORT = 4
) (
    input  logic                pin_act_i,
    input  logic [NUM_PORT-1:0] port_act_i,
    input  logic                merge_i,
    output logic                comb_o
);

    logic [NUM_PORT-1:0] gated;

    for (genvar k = 0; k < NUM_PORT; k++) begin : g_gate
        assign gated[k] = port_act_i[k] & merge_i;
    end

    assign comb_o = pin_act_i | (|gated);

endmodule

// File: rtl/xirq_detect.sv
module xirq_detect
    import xirq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic act_i,        // combined active-high source, synchronized
    input  logic level_mode_i,
    input  logic clr_i,
    output logic edge_o,
    output logic pend_o,
    output logic active_o
);

    xirq_det_t det_d, det_q;
    logic      edge_now;

    always_comb begin
        edge_now   = act_i & ~det_q.prev;
        det_d      = det_q;
        det_d.prev = act_i;
        // a fresh edge outranks a clear arriving in the same cycle
        det_d.pend = edge_now | (det_q.pend & ~clr_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            det_q <= '0;
        end else begin
            det_q <= det_d;
        end
    end

    assign edge_o   = edge_now;
    assign pend_o   = det_q.pend;
    assign active_o = det_q.pend | (level_mode_i & act_i);

endmodule

// File: rtl/xirq_unit.sv
module xirq_unit
    import xirq_pkg::*;
#(
    parameter int NUM_PORT    = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                opt_level_i,
    input  logic                opt_merge_i,
    input  logic                irq_pin_n_i,
    input  logic [NUM_PORT-1:0] port_i,
    input  logic                ack_i,
    input  logic                sw_clr_i,
    input  logic                int_en_i,
    output logic                irq_req_o
);

    localparam int SW = NUM_PORT + 1;

    xirq_ctl_t     ctl_d, ctl_q;
    logic [SW-1:0] raw_act, sync_act;
    logic          comb_w, edge_w, pend_w, active_w, clr_w;

    // option capture on the first clock after reset
    always_comb begin
        ctl_d = ctl_q;
        if (!ctl_q.armed) begin
            ctl_d.armed     = 1'b1;
            ctl_d.cfg.level = opt_level_i;
            ctl_d.cfg.merge = opt_merge_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    // normalize to active high before synchronizing
    assign raw_act = {port_i, ~irq_pin_n_i};

    xirq_sync #(.W(SW), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (raw_act),
        .q_o   (sync_act)
    );

    xirq_merge #(.NUM_PORT(NUM_PORT)) u_merge (
        .pin_act_i  (sync_act[0]),
        .port_act_i (sync_act[SW-1:1]),
        .merge_i    (ctl_q.cfg.merge),
        .comb_o     (comb_w)
    );

    assign clr_w = ack_i | sw_clr_i;

    xirq_detect u_det (
        .clk          (clk),
        .rst_n        (rst_n),
        .act_i        (comb_w),
        .level_mode_i (ctl_q.cfg.level),
        .clr_i        (clr_w),
        .edge_o       (edge_w),
        .pend_o       (pend_w),
        .active_o     (active_w)
    );

    assign irq_req_o = active_w & int_en_i;

endmodule

// File: rtl/xirq_chk.sv
module xirq_chk (
    input logic clk,
    input logic rst_n,
    input logic armed,
    input logic cfg_level,
    input logic cfg_merge,
    input logic comb,
    input logic edge_det,
    input logic pend,
    input logic clr,
    input logic en,
    input logic req
);

    // R9
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        armed |=> ($stable(cfg_level) && $stable(cfg_merge)));

    // R7
    pend_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && !clr) |=> pend);

    // R7
    clr_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !edge_det) |=> !pend);

    // R7
    edge_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
        edge_det |=> pend);

    // R8
    mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> !req);

    // R3
    edge_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && !cfg_level && !pend) |-> !req);

    // R4
    level_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && cfg_level && comb && en) |-> req);

endmodule

bind xirq_unit xirq_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .armed     (ctl_q.armed),
    .cfg_level (ctl_q.cfg.level),
    .cfg_merge (ctl_q.cfg.merge),
    .comb      (comb_w),
    .edge_det  (edge_w),
    .pend      (pend_w),
    .clr       (clr_w),
    .en        (int_en_i),
    .req       (irq_req_o)
);

// File: tb/sim_xirq_unit.sv
module sim_xirq_unit;

    localparam int  NP     = 4;
    localparam int  STG    = 2;
    localparam time PERIOD = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          opt_level = 1'b0, opt_merge = 1'b0;
    logic          pin_n = 1'b1;
    logic [NP-1:0] port = '0;
    logic          ack = 1'b0, sw_clr = 1'b0, en = 1'b1;
    logic          req;

    int checks = 0;
    int fails  = 0;

    always #(PERIOD/2) clk = ~clk;

    xirq_unit #(.NUM_PORT(NP), .SYNC_STAGES(STG)) u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .opt_level_i (opt_level),
        .opt_merge_i (opt_merge),
        .irq_pin_n_i (pin_n),
        .port_i      (port),
        .ack_i       (ack),
        .sw_clr_i    (sw_clr),
        .int_en_i    (en),
        .irq_req_o   (req)
    );

    // vector: {level, merge, pin_n, port[3:0], exp_req, exp_after_ack}
    localparam int NV = 8;
    localparam logic [8:0] VEC [NV] = '{
        {1'b0, 1'b0, 1'b0, 4'b0000, 1'b1, 1'b0},  // R2 R3
        {1'b0, 1'b0, 1'b1, 4'b1111, 1'b0, 1'b0},  // R6
        {1'b0, 1'b1, 1'b1, 4'b0001, 1'b1, 1'b0},  // R5
        {1'b0, 1'b1, 1'b1, 4'b1000, 1'b1, 1'b0},  // R5
        {1'b1, 1'b1, 1'b1, 4'b0100, 1'b1, 1'b1},  // R5 R4
        {1'b1, 1'b0, 1'b1, 4'b1111, 1'b0, 1'b0},  // R6
        {1'b1, 1'b0, 1'b0, 4'b0000, 1'b1, 1'b1},  // R4
        {1'b0, 1'b1, 1'b1, 4'b0000, 1'b0, 1'b0}   // R1 idle
    };

    task automatic chk(input string rq, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: irq_req_o=%b expected %b at %0t", rq, act, exp, $time);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset(input logic lvl, input logic mrg);
        @(negedge clk);
        rst_n = 1'b0; opt_level = lvl; opt_merge = mrg;
        pin_n = 1'b1; port = '0; ack = 1'b0; sw_clr = 1'b0; en = 1'b1;
        step(2);
        rst_n = 1'b1;
        step(1);            // capture clock
        step(STG + 1);      // flush synchronizers
    endtask

    task automatic pulse_ack;
        ack = 1'b1; step(1); ack = 1'b0;
    endtask

    initial begin
        #(PERIOD * 200000);
        fails++;
        $display("FAIL watchdog R1..: run hung, got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        // R1: reset state even with the pin held low
        pin_n = 1'b0;
        step(3);
        chk("R1", req, 1'b0);
        do_reset(1'b0, 1'b0);
        chk("R1", req, 1'b0);

        // vector table
        for (int v = 0; v < NV; v++) begin
            do_reset(VEC[v][8], VEC[v][7]);
            pin_n = VEC[v][6];
            port  = VEC[v][5:2];
            step(STG + 2);
            chk("R2/R5/R6 vector", req, VEC[v][1]);
            pulse_ack;
            step(2);
            chk("R3/R4 after ack", req, VEC[v][0]);
        end

        // R2: exact latency in edge mode
        do_reset(1'b0, 1'b0);
        pin_n = 1'b0;
        step(STG);
        chk("R2 early", req, 1'b0);
        step(1);
        chk("R2 on time", req, 1'b1);
        pin_n = 1'b1;
        step(4);
        chk("R2 held", req, 1'b1);

        // R7: edge coinciding with ack keeps latch set
        pin_n = 1'b0;
        step(STG);          // edge detected in the coming cycle
        pulse_ack;
        chk("R7 edge wins", req, 1'b1);
        sw_clr = 1'b1; step(1); sw_clr = 1'b0;
        chk("R7 sw clear", req, 1'b0);

        // R4: level mode drops after release and clear
        do_reset(1'b1, 1'b0);
        pin_n = 1'b0;
        step(STG + 2);
        pulse_ack;
        chk("R4 hold", req, 1'b1);
        pin_n = 1'b1;
        step(STG + 1);
        chk("R4 latch only", req, 1'b0);

        // R8: mask keeps pending
        do_reset(1'b0, 1'b0);
        en = 1'b0;
        pin_n = 1'b0;
        step(STG + 3);
        chk("R8 masked", req, 1'b0);
        en = 1'b1;
        #1;
        chk("R8 unmasked", req, 1'b1);

        // R9: late option change ignored
        do_reset(1'b0, 1'b0);
        opt_level = 1'b1; opt_merge = 1'b1;
        step(2);
        port = 4'b0010;
        step(STG + 2);
        chk("R9 merge ignored", req, 1'b0);
        pin_n = 1'b0;
        step(STG + 2);
        pulse_ack;
        step(1);
        chk("R9 level ignored", req, 1'b0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule